// File: doc/BRIEF.md
# Pin Event Detector

This block watches a word of input data, one bit per pin, already corrected for polarity. For every pin it records an event in a sticky status bit and raises one interrupt line shared by all pins. Each pin is set up by three configuration words. The trigger-mode word picks level or edge detection. The dual-edge word widens edge detection to both directions. The enable word decides which status bits may drive the interrupt.

Software talks to the block through a single-cycle write port: a write strobe, a word index and a data word. The enable word is written in one of three ways:

- a plain write replaces it;
- a set-alias write ORs the data into it;
- a clear-alias write removes the bits written as 1.

The status word clears the bits written as 1 and leaves the others as they are. The status word and the interrupt are the block's only outputs.

Top module: `pin_evt_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word and the trigger-mode, dual-edge and enable words all become zero, so `status` is 0 and `irq` is 0 after that edge.
- R2: A pin whose trigger-mode bit is 0 sets its status bit at a clock edge whenever its `din` bit is 1 at that edge.
- R3: A pin whose trigger-mode bit is 1 sets its status bit when `din` goes from 0 to 1 between two consecutive clock edges. A 1-to-0 change sets nothing when the dual-edge bit is 0.
- R4: A pin whose trigger-mode bit and dual-edge bit are both 1 sets its status bit on any change of its `din` bit between consecutive clock edges.
- R5: A status bit, once set, stays set until it is cleared by a write, even after its trigger condition goes away.
- R6: A write with `wr_idx` = 19 clears each status bit whose `wr_data` bit is 1 and leaves the others unchanged.
- R7: When a trigger condition and a clearing write hit the same status bit at the same edge, the bit ends up set. A level-mode pin whose input is still high therefore stays set after being cleared.
- R8: `irq` is 1 exactly when some status bit and the matching enable bit are both 1. A write with `wr_idx` = 16 replaces the enable word.
- R9: A write with `wr_idx` = 17 ORs `wr_data` into the enable word.
- R10: A write with `wr_idx` = 18 clears each enable bit whose `wr_data` bit is 1.
- R11: Writes with `wr_idx` = 10 load the trigger-mode word and writes with `wr_idx` = 11 load the dual-edge word. A write to any index other than 10, 11, 16, 17, 18 or 19 changes neither `status` nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 32 | Input data word after polarity, one bit per pin |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_idx | input | 5 | Word index of the write |
| wr_data | input | 32 | Write data |
| status | output | 32 | Sticky event status word |
| irq | output | 1 | Interrupt: OR of status AND enable |

## Verification
The hardest case to reach is a clearing write that lands on the same edge as a new trigger for the same bit. That bit must end up set, while the other bits named in the write are cleared. The directed sequence holds a level-mode pin high and clears it together with a pin whose trigger has already gone away. A random phase mixes random input toggles with writes to every index, including the status index. A behavioural model checks every cycle of both phases, so many coincident set-and-clear cases are covered in edge and dual-edge modes too.

// File: rtl/pin_evt_pkg.sv
// Shared word indices for the pin event detector.
// The write-port index of each configuration word is fixed by software.
package pin_evt_pkg;
    localparam int IDX_MODE    = 10;
    localparam int IDX_DUAL    = 11;
    localparam int IDX_ENA     = 16;
    localparam int IDX_ENA_SET = 17;
    localparam int IDX_ENA_CLR = 18;
    localparam int IDX_STAT    = 19;
endpackage

// File: rtl/pin_evt_cfg.sv
// Configuration words: trigger mode, dual edge and interrupt enable.
// The enable word has plain, set-alias and clear-alias writes.
// Assumes at most one write per cycle. Synchronous active-low reset.
module pin_evt_cfg #(
    parameter int NPINS = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] mode_q,
    output logic [NPINS-1:0] dual_q,
    output logic [NPINS-1:0] ena_q
);
    import pin_evt_pkg::*;

    localparam logic [AW-1:0] A_MODE = AW'(IDX_MODE);
    localparam logic [AW-1:0] A_DUAL = AW'(IDX_DUAL);
    localparam logic [AW-1:0] A_ENA  = AW'(IDX_ENA);
    localparam logic [AW-1:0] A_ESET = AW'(IDX_ENA_SET);
    localparam logic [AW-1:0] A_ECLR = AW'(IDX_ENA_CLR);

    logic [NPINS-1:0] ena_d;

    // Next enable word from the three ways of writing it.
    always_comb begin
        ena_d = ena_q;
        if (wr_en) begin
            case (wr_idx)
                A_ENA:   ena_d = wr_data;
                A_ESET:  ena_d = ena_q | wr_data;
                A_ECLR:  ena_d = ena_q & ~wr_data;
                default: ena_d = ena_q;
            endcase
        end
    end

    // Register the configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dual_q <= '0;
            ena_q  <= '0;
        end else begin
            if (wr_en && wr_idx == A_MODE) mode_q <= wr_data;
            if (wr_en && wr_idx == A_DUAL) dual_q <= wr_data;
            ena_q <= ena_d;
        end
    end
endmodule

// File: rtl/pin_evt_trigger.sv
// Per-pin trigger detection. An edge is a difference between din now
// and din one clock earlier. The previous value resets to 0. The
// trigger mode is zero after reset, so no edge can be seen in the first
// cycle after reset.
module pin_evt_trigger #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] din,
    input  logic [NPINS-1:0] mode_q,
    input  logic [NPINS-1:0] dual_q,
    output logic [NPINS-1:0] fire
);
    logic [NPINS-1:0] din_prev;

    // Keep last cycle's input word for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) din_prev <= '0;
        else        din_prev <= din;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic chg;
        // Per-pin trigger: high level, rising edge, or any change.
        always_comb begin
            chg = din[p] ^ din_prev[p];
            if (!mode_q[p]) fire[p] = din[p];
            else            fire[p] = chg & (din[p] | dual_q[p]);
        end
    end
endmodule

// File: rtl/pin_evt_status.sv
// Sticky status word with write-1-to-clear and the interrupt reduction.
// A trigger and a clear on the same bit in the same cycle leave it set.
module pin_evt_status #(
    parameter int NPINS = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [NPINS-1:0] wr_data,
    input  logic [NPINS-1:0] fire,
    input  logic [NPINS-1:0] ena_q,
    output logic [NPINS-1:0] stat_q,
    output logic             irq
);
    import pin_evt_pkg::*;

    localparam logic [AW-1:0] A_STAT = AW'(IDX_STAT);

    logic [NPINS-1:0] clr;

    // Bits to clear in this cycle.
    always_comb clr = (wr_en && wr_idx == A_STAT) ? wr_data : '0;

    // Sticky update: the set condition wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | fire;
    end

    // Interrupt from the enabled status bits.
    always_comb irq = |(stat_q & ena_q);
endmodule

// File: rtl/pin_evt_top.sv
// Pin event detector top: configuration, trigger detection and status.
// Assumes din is synchronous to clk and already corrected for polarity.
module pin_evt_top #(
    parameter int NPINS = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] din,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] status,
    output logic             irq
);
    logic [NPINS-1:0] mode_q;
    logic [NPINS-1:0] dual_q;
    logic [NPINS-1:0] ena_q;
    logic [NPINS-1:0] fire;

    pin_evt_cfg #(.NPINS(NPINS), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .mode_q(mode_q), .dual_q(dual_q), .ena_q(ena_q)
    );

    pin_evt_trigger #(.NPINS(NPINS)) u_trig (
        .clk(clk), .rst_n(rst_n), .din(din), .mode_q(mode_q),
        .dual_q(dual_q), .fire(fire)
    );

    pin_evt_status #(.NPINS(NPINS), .AW(AW)) u_stat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .fire(fire), .ena_q(ena_q), .stat_q(status),
        .irq(irq)
    );
endmodule

// File: rtl/pin_evt_checks.sv
// Checker for the pin event detector, bound to pin_evt_top.
// It observes the ports together with the configuration words.
module pin_evt_checks #(
    parameter int NPINS = 32,
    parameter int AW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] din,
    input logic             wr_en,
    input logic [AW-1:0]    wr_idx,
    input logic [NPINS-1:0] wr_data,
    input logic [NPINS-1:0] status,
    input logic             irq,
    input logic [NPINS-1:0] mode_q,
    input logic [NPINS-1:0] ena_q
);
    import pin_evt_pkg::*;

    logic clr_wr;
    assign clr_wr = wr_en && wr_idx == AW'(IDX_STAT);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (status == '0));

    a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(din & ~mode_q)) == $past(din & ~mode_q)));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((status & $past(status)) == $past(status)));

    a_r8_irq_reduce: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(status & ena_q));

    a_r9_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == AW'(IDX_ENA_SET)) |=>
        ((ena_q & $past(wr_data)) == $past(wr_data)));

    a_r10_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == AW'(IDX_ENA_CLR)) |=>
        ((ena_q & $past(wr_data)) == '0));
endmodule

bind pin_evt_top pin_evt_checks #(.NPINS(NPINS), .AW(AW)) u_checks (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .status(status), .irq(irq), .mode_q(mode_q),
    .ena_q(ena_q)
);

// File: tb/pin_evt_top_test.sv
module pin_evt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] din = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit compare_on = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state.
    logic [31:0] m_stat = '0, m_mode = '0, m_dual = '0, m_ena = '0, m_prev = '0;

    always #4 clk = ~clk;

    pin_evt_top uut (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .status(status), .irq(irq)
    );

    // Reference model: evaluated bit by bit from the requirements.
    always @(posedge clk) begin
        logic [31:0] ns;
        if (!rst_n) begin
            m_stat = '0; m_mode = '0; m_dual = '0; m_ena = '0; m_prev = '0;
        end else begin
            ns = m_stat;
            if (wr_en && wr_idx == 5'd19) ns = ns & ~wr_data;
            for (int i = 0; i < 32; i++) begin
                if (m_mode[i] == 1'b0 && din[i]) ns[i] = 1'b1;
                if (m_mode[i] && !m_prev[i] && din[i]) ns[i] = 1'b1;
                if (m_mode[i] && m_dual[i] && m_prev[i] != din[i]) ns[i] = 1'b1;
            end
            m_stat = ns;
            m_prev = din;
            if (wr_en) begin
                case (wr_idx)
                    5'd10: m_mode = wr_data;
                    5'd11: m_dual = wr_data;
                    5'd16: m_ena  = wr_data;
                    5'd17: m_ena  = m_ena | wr_data;
                    5'd18: m_ena  = m_ena & ~wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every cycle: compare outputs with the model.
    always @(negedge clk) begin
        if (compare_on) begin
            chk("model status", status, m_stat);
            chk("model irq", {31'd0, irq}, {31'd0, (m_stat & m_ena) != 0});
        end
    end

    // Drive one cycle of stimulus, then return at the next sampling point.
    task automatic step(logic [31:0] d, logic we, logic [4:0] idx, logic [31:0] wd);
        din = d; wr_en = we; wr_idx = idx; wr_data = wd;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status in reset", status, 32'h0);
        chk("R1 irq in reset", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        step(32'h0, 1, 5'd10, 32'hFFFF_0000);
        step(32'h0, 1, 5'd11, 32'hFF00_0000);
        chk("R1 status after reset", status, 32'h0);
        step(32'h1, 0, 0, 0);
        chk("R2 level sets", status, 32'h1);
        chk("R8 irq off while disabled", {31'd0, irq}, 32'h0);
        step(32'h0001_0001, 0, 0, 0);
        chk("R3 rising edge", status, 32'h0001_0001);
        step(32'h0001_0001, 1, 5'd19, 32'h0001_0000);
        chk("R6 clear one bit", status, 32'h1);
        step(32'h0000_0001, 0, 0, 0);
        chk("R3 falling ignored", status, 32'h1);
        step(32'h0100_0001, 0, 0, 0);
        step(32'h0100_0001, 1, 5'd19, 32'h0100_0000);
        step(32'h0000_0001, 0, 0, 0);
        chk("R4 falling with dual", status, 32'h0100_0001);
        step(32'h3, 0, 0, 0);
        step(32'h1, 0, 0, 0);
        chk("R5 sticky", status, 32'h0100_0003);
        step(32'h1, 1, 5'd19, 32'h3);
        chk("R7 set wins over clear", status, 32'h0100_0001);
        step(32'h1, 1, 5'd16, 32'h2);
        chk("R8 irq off", {31'd0, irq}, 32'h0);
        step(32'h1, 1, 5'd17, 32'h0100_0000);
        chk("R9 set alias", {31'd0, irq}, 32'h1);
        step(32'h1, 1, 5'd18, 32'h0100_0000);
        chk("R10 clear alias", {31'd0, irq}, 32'h0);
        step(32'h1, 1, 5'd5, 32'hFFFF_FFFF);
        chk("R11 other index status", status, 32'h0100_0001);
        chk("R11 other index irq", {31'd0, irq}, 32'h0);
        step(32'h3, 0, 0, 0);
        chk("R8 irq on", {31'd0, irq}, 32'h1);
        step(32'h1, 1, 5'd16, 32'h0);
        chk("R8 plain write", {31'd0, irq}, 32'h0);
        step(32'h1, 1, 5'd10, 32'h0);
        step(32'h1, 1, 5'd19, 32'hFFFF_FFFF);
        chk("R11 mode reload to level", status, 32'h1);
        // Random phase: random inputs and writes, checked against the model.
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] ix;
            case ($urandom_range(0, 7))
                0: ix = 5'd10;
                1: ix = 5'd11;
                2: ix = 5'd16;
                3: ix = 5'd17;
                4: ix = 5'd18;
                5: ix = 5'd19;
                6: ix = 5'd19;
                default: ix = 5'($urandom_range(0, 31));
            endcase
            step($urandom() & $urandom(), ($urandom_range(0, 2) == 0), ix,
                 $urandom());
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 status after late reset", status, 32'h0);
        compare_on = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule